// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block guards the delayed-transaction entry that sits at the head of each of a bridge's two request queues (one per bus side). When an entry reaches the head, a per-side counter starts counting bus clocks while the bridge waits for the original initiator to repeat its request. A matching retry stops the count and the entry is kept. If the programmed limit runs out first, the block emits a one-clock discard pulse so that the queue logic drops the entry.

Each side has its own counter and its own length select: long (2^15 clocks) or short (2^10 clocks). Both sides share one sticky expiry status bit, which software clears by writing 1. An optional active-low system-error request pulses together with any discard when error reporting is enabled. Queue storage, request matching and bus protocol belong to the surrounding logic. The queue signals a new head entry by taking the head-valid input low for at least one clock between entries.

Top module: `dtx_discard_timer`

## Requirements
- R1: After reset, both discard outputs are 0, `expire_sts` is 0 and `serr_req_n` is 1.
- R2: While a side's head-valid is 1 and no retry is seen, the discard output of that side is 1 for exactly one clock. That clock is the one after the L-th consecutive rising edge at which head-valid was sampled 1. L is 1024 when the side's short-select is 1 and 32768 when it is 0.
- R3: A retry strobe sampled together with head-valid at any counting edge, including the L-th, cancels the entry's timer. No discard is produced for that entry.
- R4: Head-valid sampled 0 at any edge returns the side to idle and resets its count to zero. An entry held at the head after its discard or its retry produces no further discard.
- R5: The two sides count independently. Activity on one side never changes the timing of the other side.
- R6: `expire_sts` becomes 1 in the same clock that either discard output is 1. It stays 1 until a clock after an edge at which `sts_clr_w1` was sampled 1.
- R7: When `sts_clr_w1` is sampled at the same edge as an expiry, the set wins and `expire_sts` stays 1.
- R8: `serr_req_n` is 0 for exactly the clock(s) in which a discard output is 1, if `serr_en` was 1 at the expiring edge. Otherwise it stays 1.
- R9: Short-select is applied live. If a side switches from long to short while its count is already at or past 1023, it expires at the next counting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_head_vld | input | 1 | Primary-side queue head holds a delayed entry |
| pri_retry_hit | input | 1 | Primary-side initiator repeated the head request |
| pri_short_sel | input | 1 | Primary-side limit: 1 = 2^10, 0 = 2^15 clocks |
| sec_head_vld | input | 1 | Secondary-side queue head holds a delayed entry |
| sec_retry_hit | input | 1 | Secondary-side initiator repeated the head request |
| sec_short_sel | input | 1 | Secondary-side limit: 1 = 2^10, 0 = 2^15 clocks |
| serr_en | input | 1 | Enables the system-error request on expiry |
| sts_clr_w1 | input | 1 | Write-1 strobe clearing the expiry status |
| pri_discard | output | 1 | One-clock pulse: drop the primary head entry |
| sec_discard | output | 1 | One-clock pulse: drop the secondary head entry |
| expire_sts | output | 1 | Sticky expiry status, shared by both sides |
| serr_req_n | output | 1 | Active-low system-error request |

## Verification
A count that is off by one or that fails to restart shows up as a discard pulse one or more clocks away from the predicted edge. The scoreboard compares each pulse against the exact expected cycle, so such a fault is caught in the same clock it happens. A state that stays in counting after a retry, or that re-arms while the entry is held, produces an unexpected pulse within one timeout period, at most 1024 or 32768 clocks later. A stuck or wrongly prioritised status bit is visible at `expire_sts` one clock after the clear strobe.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int NUM_SIDES = 2;
  localparam int SIDE_PRI  = 0;
  localparam int SIDE_SEC  = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/dtx_side_timer.sv
module dtx_side_timer
  import dtx_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int SHORT_EXP = 10,
  parameter int LONG_EXP  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic head_vld,
  input  logic retry_hit,
  input  logic short_sel,
  output logic expire_o,
  output logic discard_o
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((1 << SHORT_EXP) - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((1 << LONG_EXP) - 1);

  tmr_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] last_cnt;
  logic             cnt_en;
  logic             expire_n;
  logic             disc_q;

  assign last_cnt = short_sel ? SHORT_LAST : LONG_LAST;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    expire_n = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_COUNT: begin
        if (!head_vld) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else if (retry_hit) begin
          state_n = ST_HOLD;
          cnt_n   = '0;
        end else if (cnt_q >= last_cnt) begin
          state_n  = ST_HOLD;
          cnt_n    = '0;
          expire_n = 1'b1;
        end else begin
          state_n = ST_COUNT;
          cnt_n   = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!head_vld) state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  assign cnt_en = (state_q != ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      disc_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
      disc_q  <= expire_n;
    end
  end

  assign expire_o  = expire_n;
  assign discard_o = disc_q;
endmodule

// File: rtl/dtx_status_ctl.sv
module dtx_status_ctl
  import dtx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SIDES-1:0] expire_vec,
  input  logic                 clr_w1,
  input  logic                 serr_en,
  output logic                 sts_o,
  output logic                 serr_n_o
);
  logic any_exp;
  logic sts_q, sts_n;
  logic serr_n_q, serr_n_n;

  assign any_exp = |expire_vec;

  always_comb begin
    sts_n    = (sts_q & ~clr_w1) | any_exp;
    serr_n_n = ~(serr_en & any_exp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= 1'b0;
      serr_n_q <= 1'b1;
    end else begin
      sts_q    <= sts_n;
      serr_n_q <= serr_n_n;
    end
  end

  assign sts_o    = sts_q;
  assign serr_n_o = serr_n_q;
endmodule

// File: rtl/dtx_discard_timer.sv
module dtx_discard_timer
  import dtx_pkg::*;
#(
  parameter int CNT_W     = 15,
  parameter int SHORT_EXP = 10,
  parameter int LONG_EXP  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_head_vld,
  input  logic pri_retry_hit,
  input  logic pri_short_sel,
  input  logic sec_head_vld,
  input  logic sec_retry_hit,
  input  logic sec_short_sel,
  input  logic serr_en,
  input  logic sts_clr_w1,
  output logic pri_discard,
  output logic sec_discard,
  output logic expire_sts,
  output logic serr_req_n
);
  logic [NUM_SIDES-1:0] vld_vec, retry_vec, short_vec;
  logic [NUM_SIDES-1:0] exp_vec, disc_vec;

  assign vld_vec[SIDE_PRI]   = pri_head_vld;
  assign vld_vec[SIDE_SEC]   = sec_head_vld;
  assign retry_vec[SIDE_PRI] = pri_retry_hit;
  assign retry_vec[SIDE_SEC] = sec_retry_hit;
  assign short_vec[SIDE_PRI] = pri_short_sel;
  assign short_vec[SIDE_SEC] = sec_short_sel;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dtx_side_timer #(
      .CNT_W    (CNT_W),
      .SHORT_EXP(SHORT_EXP),
      .LONG_EXP (LONG_EXP)
    ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .head_vld (vld_vec[s]),
      .retry_hit(retry_vec[s]),
      .short_sel(short_vec[s]),
      .expire_o (exp_vec[s]),
      .discard_o(disc_vec[s])
    );
  end

  dtx_status_ctl u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_vec(exp_vec),
    .clr_w1    (sts_clr_w1),
    .serr_en   (serr_en),
    .sts_o     (expire_sts),
    .serr_n_o  (serr_req_n)
  );

  assign pri_discard = disc_vec[SIDE_PRI];
  assign sec_discard = disc_vec[SIDE_SEC];
endmodule

// File: rtl/dtx_discard_timer_chk.sv
module dtx_discard_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic pri_head_vld,
  input logic pri_retry_hit,
  input logic sec_head_vld,
  input logic sec_retry_hit,
  input logic serr_en,
  input logic pri_discard,
  input logic sec_discard,
  input logic expire_sts,
  input logic serr_req_n
);
  // R2: a discard lasts a single clock
  p_pri_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pri_discard |=> !pri_discard);
  p_sec_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_discard |=> !sec_discard);

  // R3: a retry at a counting edge forbids a discard right after it
  p_pri_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_head_vld && pri_retry_hit) |=> !pri_discard);
  p_sec_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_head_vld && sec_retry_hit) |=> !sec_discard);

  // R4: no head entry, no discard next clock
  p_pri_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_head_vld |=> !pri_discard);
  p_sec_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_head_vld |=> !sec_discard);

  // R6: status visible together with every discard
  p_sts_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_discard || sec_discard) |-> expire_sts);

  // R6: status only rises because of a discard
  p_sts_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire_sts) |-> (pri_discard || sec_discard));

  // R8: error request only with a discard and an enabled report
  p_serr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_req_n |-> ((pri_discard || sec_discard) && $past(serr_en)));
endmodule

bind dtx_discard_timer dtx_discard_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pri_head_vld (pri_head_vld),
  .pri_retry_hit(pri_retry_hit),
  .sec_head_vld (sec_head_vld),
  .sec_retry_hit(sec_retry_hit),
  .serr_en      (serr_en),
  .pri_discard  (pri_discard),
  .sec_discard  (sec_discard),
  .expire_sts   (expire_sts),
  .serr_req_n   (serr_req_n)
);

// File: tb/dtx_discard_timer_tb.sv
`timescale 1ns/1ps
module dtx_discard_timer_tb;
  localparam int L_SHORT = 1024;
  localparam int L_LONG  = 32768;

  typedef struct {
    int side;
    int cyc;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic pri_head_vld, pri_retry_hit, pri_short_sel;
  logic sec_head_vld, sec_retry_hit, sec_short_sel;
  logic serr_en, sts_clr_w1;
  logic pri_discard, sec_discard, expire_sts, serr_req_n;

  int        cyc = 0;
  int        total = 0;
  int        bad = 0;
  bit        finished = 1'b0;
  exp_item_t exp_q[$];

  always #2.5 clk = ~clk;

  dtx_discard_timer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pri_head_vld (pri_head_vld),
    .pri_retry_hit(pri_retry_hit),
    .pri_short_sel(pri_short_sel),
    .sec_head_vld (sec_head_vld),
    .sec_retry_hit(sec_retry_hit),
    .sec_short_sel(sec_short_sel),
    .serr_en      (serr_en),
    .sts_clr_w1   (sts_clr_w1),
    .pri_discard  (pri_discard),
    .sec_discard  (sec_discard),
    .expire_sts   (expire_sts),
    .serr_req_n   (serr_req_n)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic expect_discard(input int side, input int at);
    exp_item_t it;
    it.side = side;
    it.cyc  = at;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor: every discard must match a predicted item
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int s = 0; s < 2; s++) begin
        logic d;
        bit   hit;
        d   = (s == 0) ? pri_discard : sec_discard;
        hit = 1'b0;
        if (d) begin
          for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (!hit && exp_q[i].side == s && exp_q[i].cyc == cyc) begin
              exp_q.delete(i);
              hit = 1'b1;
            end
          end
          chk($sformatf("R2 discard side %0d predicted", s), int'(hit), 1);
          chk("R8 serr follows enable", int'(serr_req_n), int'(!serr_en));
        end
      end
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
        if (exp_q[i].cyc < cyc) begin
          chk($sformatf("R2 missed discard side %0d at %0d", exp_q[i].side, exp_q[i].cyc), 0, 1);
          exp_q.delete(i);
        end
      end
      if (!pri_discard && !sec_discard && !serr_req_n)
        chk("R8 serr without discard", int'(serr_req_n), 1);
    end
  end

  task automatic clear_sts();
    sts_clr_w1 = 1'b1;
    tick();
    sts_clr_w1 = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c, c2;
    rst_n = 1'b0;
    pri_head_vld = 0; pri_retry_hit = 0; pri_short_sel = 0;
    sec_head_vld = 0; sec_retry_hit = 0; sec_short_sel = 0;
    serr_en = 0; sts_clr_w1 = 0;
    repeat (3) tick();
    chk("R1 pri_discard reset", int'(pri_discard), 0);
    chk("R1 sec_discard reset", int'(sec_discard), 0);
    chk("R1 expire_sts reset", int'(expire_sts), 0);
    chk("R1 serr_req_n reset", int'(serr_req_n), 1);
    rst_n = 1'b1;
    tick();

    // R2 short expiry on primary with error reporting
    pri_short_sel = 1; serr_en = 1;
    c = cyc; pri_head_vld = 1;
    expect_discard(0, c + L_SHORT);
    wait_to(c + L_SHORT - 1);
    chk("R2 no pulse one clock early", int'(pri_discard), 0);
    tick();
    chk("R2 pulse at limit", int'(pri_discard), 1);
    chk("R6 status with pulse", int'(expire_sts), 1);
    chk("R8 serr low with pulse", int'(serr_req_n), 0);
    tick();
    chk("R2 pulse one clock wide", int'(pri_discard), 0);
    chk("R8 serr released", int'(serr_req_n), 1);
    pri_head_vld = 0;
    tick();

    // R6 write-1 clear
    chk("R6 status sticky", int'(expire_sts), 1);
    clear_sts();
    chk("R6 status cleared", int'(expire_sts), 0);

    // R3 retry midway cancels; R4 held entry stays quiet
    c = cyc; pri_head_vld = 1;
    wait_to(c + 500);
    pri_retry_hit = 1; tick(); pri_retry_hit = 0;
    wait_to(c + 2100);
    chk("R3 no discard after retry", int'(pri_discard), 0);
    chk("R4 status untouched after retry", int'(expire_sts), 0);
    pri_head_vld = 0; tick();

    // R3 retry on the very edge of expiry
    c = cyc; pri_head_vld = 1;
    wait_to(c + L_SHORT - 1);
    pri_retry_hit = 1; tick(); pri_retry_hit = 0;
    tick();
    chk("R3 same-edge retry wins", int'(pri_discard), 0);
    chk("R3 no status on same-edge retry", int'(expire_sts), 0);
    pri_head_vld = 0; tick();

    // R4 head drop restarts the count
    c = cyc; pri_head_vld = 1;
    wait_to(c + 600);
    pri_head_vld = 0; tick();
    c2 = cyc; pri_head_vld = 1;
    expect_discard(0, c2 + L_SHORT);
    wait_to(c2 + L_SHORT);
    chk("R4 restart from zero", int'(pri_discard), 1);
    wait_to(c2 + L_SHORT + 1100);
    chk("R4 held entry no repeat", int'(pri_discard), 0);
    pri_head_vld = 0; tick();
    clear_sts();

    // R5 independent sides, long vs short; R8 disabled report
    serr_en = 0; pri_short_sel = 0; sec_short_sel = 1;
    c = cyc; pri_head_vld = 1;
    expect_discard(0, c + L_LONG);
    wait_to(c + 300);
    sec_head_vld = 1;
    expect_discard(1, c + 300 + L_SHORT);
    wait_to(c + 300 + L_SHORT);
    chk("R5 secondary expires alone", int'(sec_discard), 1);
    chk("R5 primary still counting", int'(pri_discard), 0);
    chk("R8 serr held high when disabled", int'(serr_req_n), 1);
    tick(); sec_head_vld = 0;
    wait_to(c + L_LONG);
    chk("R5 primary long limit", int'(pri_discard), 1);
    chk("R8 serr high on long expiry", int'(serr_req_n), 1);
    tick(); pri_head_vld = 0;
    clear_sts();

    // R7 set beats clear
    serr_en = 1; pri_short_sel = 1;
    c = cyc; pri_head_vld = 1;
    expect_discard(0, c + L_SHORT);
    wait_to(c + L_SHORT - 1);
    sts_clr_w1 = 1; tick(); sts_clr_w1 = 0;
    chk("R7 set wins over clear", int'(expire_sts), 1);
    tick();
    clear_sts();
    chk("R6 clear after collision", int'(expire_sts), 0);
    pri_head_vld = 0; tick();

    // R9 live switch to short past the short limit
    pri_short_sel = 0;
    c = cyc; pri_head_vld = 1;
    wait_to(c + 2000);
    pri_short_sel = 1;
    expect_discard(0, c + 2001);
    tick();
    chk("R9 switch expires next edge", int'(pri_discard), 1);
    pri_head_vld = 0;
    repeat (5) tick();
    chk("R2 all predicted discards seen", exp_q.size(), 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule